// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks a freshly powered DRAM through its start-up command stream. After a start pulse it emits a fixed list of 32-bit direct-command words, one per completed valid/ready handshake, to a downstream command port. The list depends on the memory family selected at start: DDR2, LPDDR or LPDDR2. The mode-register and extended-mode-register values come from build-time parameters for write recovery, CAS latency and burst code.

When a second chip select is enabled, the whole list is issued again for that chip. For LPDDR2 the sequencer ends each chip's list by reading the mode register repeatedly. It stops reading once a busy status input reports that the device has finished its own initialisation. A bounded retry count protects against a device that never becomes idle.

A sticky done flag marks a clean finish. An error flag marks an unsupported family code or an exhausted poll budget.

Top module: `dram_init_seq`

## Requirements
- R1: Every command word carries the opcode in bits [27:24], the chip select in bit 20, the bank in bits [18:16] and the address in bits [15:0]. All other bits are zero. Opcodes are: mode-register set 0, precharge-all 1, auto-refresh 5, no-operation 7, mode-register read 9.
- R2: The mode-register address equals ((WR_CYC-1)<<9) | (CAS_LAT<<4) | BURST_CODE. The DLL-reset form additionally sets bit 8.
- R3: With family code 0 (DDR2), each chip receives these 12 words in order:
  - no-operation;
  - precharge-all;
  - mode set to bank 2, then to bank 3, each with address 0;
  - mode set to bank 1 with 0x400;
  - mode set to bank 0 with the DLL-reset value;
  - precharge-all;
  - two auto-refreshes;
  - mode set to bank 0 with the plain value;
  - mode set to bank 1 with 0x780;
  - mode set to bank 1 with 0x400.
- R4: With family code 1 (LPDDR), each chip receives 5 words in order: precharge-all, two auto-refreshes, mode set to bank 0 with the plain value, then mode set to bank 1 with 0x400.
- R5: With family code 2 (LPDDR2), each chip receives no-operation, then mode set to bank 0 with the plain value, then mode-register reads. The block samples mr_busy_i in the cycle after each read handshake. It issues another read while the sample is 1 and moves on when the sample is 0.
- R6: The list runs for chip 0. It repeats with the chip bit set only if dual_cs_i was 1 when start was accepted.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_word_o is unchanged. Exactly one word is consumed per handshake.
- R8: A start pulse while busy_o is high is ignored, including in the cycle of the final handshake.
- R9: After the final handshake, done_o is 1 and busy_o is 0. done_o stays 1 until the next accepted start clears it.
- R10: Family code 3 sets err_o, issues no command and leaves done_o at 0.
- R11: If POLL_LIMIT consecutive reads all sample busy, err_o is set and the sequence stops. A clear sample on the last allowed read still counts as success.
- R12: After reset, cmd_valid_o, busy_o, done_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mem_kind_i | input | 2 | Memory family: 0 DDR2, 1 LPDDR, 2 LPDDR2, 3 unsupported |
| dual_cs_i | input | 1 | Second chip select present |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Command port accepts the word |
| cmd_word_o | output | 32 | Direct-command word |
| mr_busy_i | input | 1 | Status bit 0: device auto-initialisation busy |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished cleanly (sticky) |
| err_o | output | 1 | Unsupported family or poll timeout (sticky) |

## Verification
A start pulse can land in the same cycle as the handshake that consumes the final command word. The bench provokes this by raising start, with a different family code, on the exact cycle the last LPDDR word is accepted. It judges the outcome in three ways: done_o rises, busy_o falls, and the scoreboard sees no further words for twenty cycles.

The poll budget running out can also coincide with the status clearing. The bench lets the status clear on precisely the last allowed read. It expects success there, and an error when the status stays busy.

// File: rtl/dram_init_pkg.sv
`timescale 1ns/1ps
package dram_init_pkg;

  localparam int STEP_W = 4;

  localparam logic [1:0] KIND_DDR2 = 2'd0;
  localparam logic [1:0] KIND_LP1  = 2'd1;
  localparam logic [1:0] KIND_LP2  = 2'd2;
  localparam logic [1:0] KIND_BAD  = 2'd3;

  localparam logic [3:0] OP_MRS  = 4'd0;
  localparam logic [3:0] OP_PALL = 4'd1;
  localparam logic [3:0] OP_REFA = 4'd5;
  localparam logic [3:0] OP_NOP  = 4'd7;
  localparam logic [3:0] OP_MRR  = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_POLL} seq_state_e;

  // number of entries in each family's per-chip script
  function automatic logic [STEP_W-1:0] script_len(input logic [1:0] kind);
    case (kind)
      KIND_DDR2: script_len = STEP_W'(12);
      KIND_LP1:  script_len = STEP_W'(5);
      default:   script_len = STEP_W'(3);
    endcase
  endfunction

  function automatic logic [31:0] pack_cmd(input logic [3:0] op, input logic chip,
                                           input logic [2:0] bank, input logic [15:0] row);
    pack_cmd = {4'd0, op, 3'd0, chip, 1'b0, bank, row};
  endfunction

endpackage

// File: rtl/dram_init_script.sv
`timescale 1ns/1ps
module dram_init_script
  import dram_init_pkg::*;
#(
  parameter int WR_CYC     = 3,
  parameter int CAS_LAT    = 3,
  parameter int BURST_CODE = 2
) (
  input  logic [1:0]        kind,
  input  logic [STEP_W-1:0] step,
  input  logic              chip,
  output logic [31:0]       word
);

  localparam logic [15:0] MR_PLAIN = 16'((WR_CYC - 1) * 512 + CAS_LAT * 16 + BURST_CODE);
  localparam logic [15:0] MR_DLLRST = MR_PLAIN | 16'h0100;
  localparam logic [15:0] EMR_BASE  = 16'h0400;
  localparam logic [15:0] EMR_OCD   = 16'h0780;

  logic [3:0]  op;
  logic [2:0]  bank;
  logic [15:0] row;

  always_comb begin
    op   = OP_NOP;
    bank = 3'd0;
    row  = 16'd0;
    case (kind)
      KIND_DDR2: begin
        case (step)
          4'd0:  op = OP_NOP;
          4'd1:  op = OP_PALL;
          4'd2:  begin op = OP_MRS; bank = 3'd2; end
          4'd3:  begin op = OP_MRS; bank = 3'd3; end
          4'd4:  begin op = OP_MRS; bank = 3'd1; row = EMR_BASE; end
          4'd5:  begin op = OP_MRS; row = MR_DLLRST; end
          4'd6:  op = OP_PALL;
          4'd7:  op = OP_REFA;
          4'd8:  op = OP_REFA;
          4'd9:  begin op = OP_MRS; row = MR_PLAIN; end
          4'd10: begin op = OP_MRS; bank = 3'd1; row = EMR_OCD; end
          default: begin op = OP_MRS; bank = 3'd1; row = EMR_BASE; end
        endcase
      end
      KIND_LP1: begin
        case (step)
          4'd0:  op = OP_PALL;
          4'd1:  op = OP_REFA;
          4'd2:  op = OP_REFA;
          4'd3:  begin op = OP_MRS; row = MR_PLAIN; end
          default: begin op = OP_MRS; bank = 3'd1; row = EMR_BASE; end
        endcase
      end
      default: begin
        case (step)
          4'd0:  op = OP_NOP;
          4'd1:  begin op = OP_MRS; row = MR_PLAIN; end
          default: op = OP_MRR;
        endcase
      end
    endcase
    word = pack_cmd(op, chip, bank, row);
  end

endmodule

// File: rtl/dram_init_poll.sv
`timescale 1ns/1ps
module dram_init_poll #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = tick && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/dram_init_seq.sv
`timescale 1ns/1ps
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int WR_CYC     = 3,
  parameter int CAS_LAT    = 3,
  parameter int BURST_CODE = 2,
  parameter int POLL_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [1:0]  mem_kind_i,
  input  logic        dual_cs_i,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [31:0] cmd_word_o,
  input  logic        mr_busy_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);

  seq_state_e        state_q;
  logic [1:0]        kind_q;
  logic              dual_q;
  logic [STEP_W-1:0] step_q;
  logic              chip_q;
  logic [31:0]       word_q;
  logic              done_q;
  logic              err_q;

  logic              at_last, to_chip1, finish, poll_step, advance;
  logic [STEP_W-1:0] nxt_step, ld_step;
  logic              nxt_chip, ld_chip;
  logic [1:0]        ld_kind;
  logic [31:0]       rom_word;
  logic              poll_tick, poll_clear, poll_expired;

  always_comb begin
    at_last   = (step_q == script_len(kind_q) - 1'b1);
    to_chip1  = at_last && !chip_q && dual_q;
    finish    = at_last && !to_chip1;
    nxt_step  = at_last ? '0 : step_q + 1'b1;
    nxt_chip  = to_chip1 ? 1'b1 : chip_q;
    poll_step = (kind_q == KIND_LP2) && at_last;
    advance   = ((state_q == ST_ISSUE) && cmd_ready_i && !poll_step) ||
                ((state_q == ST_POLL) && !mr_busy_i);
    ld_kind   = (state_q == ST_IDLE) ? mem_kind_i : kind_q;
    ld_step   = (state_q == ST_IDLE) ? '0 : nxt_step;
    ld_chip   = (state_q == ST_IDLE) ? 1'b0 : nxt_chip;
    poll_tick  = (state_q == ST_POLL) && mr_busy_i;
    poll_clear = advance || ((state_q == ST_IDLE) && start_i);
  end

  dram_init_script #(
    .WR_CYC(WR_CYC), .CAS_LAT(CAS_LAT), .BURST_CODE(BURST_CODE)
  ) i_script (
    .kind(ld_kind), .step(ld_step), .chip(ld_chip), .word(rom_word)
  );

  dram_init_poll #(.LIMIT(POLL_LIMIT)) i_poll (
    .clk(clk), .rst(rst), .clear(poll_clear), .tick(poll_tick), .expired(poll_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_DDR2;
      dual_q  <= 1'b0;
      step_q  <= '0;
      chip_q  <= 1'b0;
      word_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q <= 1'b0;
            if (mem_kind_i == KIND_BAD) begin
              err_q <= 1'b1;
            end else begin
              err_q   <= 1'b0;
              kind_q  <= mem_kind_i;
              dual_q  <= dual_cs_i;
              step_q  <= '0;
              chip_q  <= 1'b0;
              word_q  <= rom_word;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (advance) begin
            if (finish) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              step_q  <= nxt_step;
              chip_q  <= nxt_chip;
              word_q  <= rom_word;
              state_q <= ST_ISSUE;
            end
          end else if (state_q == ST_ISSUE) begin
            if (cmd_ready_i) state_q <= ST_POLL;
          end else if (poll_expired) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_word_o  = word_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

endmodule

// File: rtl/dram_init_chk.sv
`timescale 1ns/1ps
module dram_init_chk (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_word_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

  assert_layout_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (cmd_word_o[31:28] == 4'd0 && cmd_word_o[23:21] == 3'd0 && !cmd_word_o[19]));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!busy_o && !err_o));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !done_o);

  assert_err_stops_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !cmd_valid_o);

endmodule

bind dram_init_seq dram_init_chk i_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;

  localparam int WR = 3, CAS = 3, BC = 2, LIM = 4;
  localparam logic [15:0] MRV = 16'((WR - 1) * 512 + CAS * 16 + BC);

  logic        clk = 1'b0, rst = 1'b1, start_i = 1'b0, dual_cs_i = 1'b0;
  logic [1:0]  mem_kind_i = 2'd0;
  logic        cmd_valid_o, cmd_ready_i, mr_busy_i, busy_o, done_o, err_o;
  logic [31:0] cmd_word_o;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          n_cmp = 0, n_bad = 0, mrr_cnt = 0, mrr_need = 0, cyc = 0;
  logic [7:0]  rdy_pat = 8'hFF;
  logic        hold_pend = 1'b0;
  logic [31:0] hold_word;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign cmd_ready_i = rdy_pat[cyc[2:0]];
  assign mr_busy_i   = (mrr_cnt < mrr_need);

  dram_init_seq #(.WR_CYC(WR), .CAS_LAT(CAS), .BURST_CODE(BC), .POLL_LIMIT(LIM)) i_dram_init_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_kind_i(mem_kind_i), .dual_cs_i(dual_cs_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o),
    .mr_busy_i(mr_busy_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  function automatic logic [31:0] mk(input int op, input int chip, input int bank, input logic [15:0] row);
    mk = (32'(op) << 24) | (32'(chip) << 20) | (32'(bank) << 16) | 32'(row);
  endfunction

  task automatic push(input logic [31:0] w, input string t);
    exp_q.push_back(w); tag_q.push_back(t);
  endtask

  task automatic push_ddr2(input int c);
    push(mk(7, c, 0, 0), "R3"); push(mk(1, c, 0, 0), "R3");
    push(mk(0, c, 2, 0), "R3"); push(mk(0, c, 3, 0), "R3");
    push(mk(0, c, 1, 16'h0400), "R3"); push(mk(0, c, 0, MRV | 16'h0100), "R2");
    push(mk(1, c, 0, 0), "R3"); push(mk(5, c, 0, 0), "R3"); push(mk(5, c, 0, 0), "R3");
    push(mk(0, c, 0, MRV), "R2"); push(mk(0, c, 1, 16'h0780), "R3");
    push(mk(0, c, 1, 16'h0400), "R3");
  endtask

  task automatic push_lp1(input int c);
    push(mk(1, c, 0, 0), "R4"); push(mk(5, c, 0, 0), "R4"); push(mk(5, c, 0, 0), "R4");
    push(mk(0, c, 0, MRV), "R2"); push(mk(0, c, 1, 16'h0400), "R4");
  endtask

  task automatic push_lp2(input int c, input int nrd);
    push(mk(7, c, 0, 0), "R5"); push(mk(0, c, 0, MRV), "R2");
    for (int k = 0; k < nrd; k++) push(mk(9, c, 0, 0), "R5");
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] k, input logic d);
    @(negedge clk); start_i = 1'b1; mem_kind_i = k; dual_cs_i = d;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run(input logic [1:0] k, input logic d);
    pulse(k, d);
    while (busy_o) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        n_cmp++;
        if (!cmd_valid_o || cmd_word_o !== hold_word) begin
          n_bad++;
          $display("FAIL R7 act=%h exp=%h", cmd_word_o, hold_word);
        end
        hold_pend = 1'b0;
      end
      if (cmd_valid_o && !cmd_ready_i) begin
        hold_pend = 1'b1; hold_word = cmd_word_o;
      end
      if (cmd_valid_o && cmd_ready_i) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8 unexpected word act=%h exp=none", cmd_word_o);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (cmd_word_o !== e) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, cmd_word_o, e);
          end
        end
        if (cmd_word_o[27:24] == 4'd9) mrr_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 valid", 32'(cmd_valid_o), 0); chk("R12 busy", 32'(busy_o), 0);
    chk("R12 done", 32'(done_o), 0);       chk("R12 err", 32'(err_o), 0);

    // R3 DDR2 single chip, ready always
    push_ddr2(0); run(2'd0, 1'b0);
    chk("R9 done", 32'(done_o), 1); chk("R9 err", 32'(err_o), 0);
    chk("R3 drained", 32'(exp_q.size()), 0);

    // R6 R7 DDR2 dual chip with stalls
    rdy_pat = 8'b1011_0010;
    push_ddr2(0); push_ddr2(1); run(2'd0, 1'b1);
    chk("R6 drained", 32'(exp_q.size()), 0); chk("R6 done", 32'(done_o), 1);

    // R4 LPDDR single chip with stalls
    rdy_pat = 8'b0110_1101;
    push_lp1(0); run(2'd1, 1'b0);
    chk("R4 drained", 32'(exp_q.size()), 0);

    // R5 LPDDR2 dual: chip0 needs two reads, chip1 one
    rdy_pat = 8'hFF;
    mrr_need = mrr_cnt + 2;
    push_lp2(0, 2); push_lp2(1, 1); run(2'd2, 1'b1);
    chk("R5 drained", 32'(exp_q.size()), 0); chk("R5 done", 32'(done_o), 1);

    // R11 status clears on the last allowed read: success
    mrr_need = mrr_cnt + LIM;
    push_lp2(0, LIM); run(2'd2, 1'b0);
    chk("R11 edge done", 32'(done_o), 1); chk("R11 edge err", 32'(err_o), 0);

    // R11 status never clears: timeout error
    mrr_need = mrr_cnt + 1000;
    push_lp2(0, LIM); run(2'd2, 1'b0);
    @(negedge clk);
    chk("R11 err", 32'(err_o), 1); chk("R11 done", 32'(done_o), 0);
    chk("R11 drained", 32'(exp_q.size()), 0);
    mrr_need = mrr_cnt;

    // R10 unsupported family
    pulse(2'd3, 1'b0);
    chk("R10 err", 32'(err_o), 1); chk("R10 done", 32'(done_o), 0);
    chk("R10 busy", 32'(busy_o), 0);
    repeat (10) @(negedge clk);
    chk("R10 valid", 32'(cmd_valid_o), 0);

    // R8 start while busy, and start on the final handshake cycle
    push_lp1(0);
    pulse(2'd1, 1'b0);
    @(negedge clk); start_i = 1'b1; mem_kind_i = 2'd0;
    @(negedge clk); start_i = 1'b0;
    while (!(cmd_valid_o && cmd_word_o == mk(0, 0, 1, 16'h0400))) @(negedge clk);
    start_i = 1'b1; mem_kind_i = 2'd0;
    @(negedge clk); start_i = 1'b0;
    chk("R8 busy", 32'(busy_o), 0); chk("R9 done", 32'(done_o), 1);
    repeat (20) @(negedge clk);
    chk("R8 drained", 32'(exp_q.size()), 0); chk("R9 sticky", 32'(done_o), 1);

    // R9 done cleared by the next accepted start
    push_lp1(1); push_lp1(0);
    exp_q.delete(); tag_q.delete();
    push_lp1(0);
    pulse(2'd1, 1'b0);
    chk("R9 cleared", 32'(done_o), 0);
    while (busy_o) @(negedge clk);
    chk("R9 done again", 32'(done_o), 1);
    chk("R4 drained again", 32'(exp_q.size()), 0);

    finish_run();
  end

endmodule